// File: doc/BRIEF.md
# Grouped Execution Unit Allocator

This block keeps track of which execution units are free and turns each issue request into one concrete unit. Units and groups of units share one resource numbering. Every resource owns one identity bit. A group's request mask is its own bit ORed with the full masks of its direct members, and a member may itself be a group. A request names a unit or a group. The block walks down the hierarchy to a free plain unit, choosing in round-robin order at each group level. It then holds that unit busy for the requested number of cycles.

Each group keeps a rotation mask of its direct members and a removed set. When a member fills up, it leaves the rotation of every group that contains it. Members that leave above the current candidate are held out of the next reload of the rotation. Group occupancy always follows from the members: a group is free exactly when at least one of its members is free. When a unit's busy time runs out, the unit is reported on a freed bitmap.

Top module: `grouped_unit_alloc`

## Requirements
- R1: Resource i owns identity bit i. Plain units take indices 0..NUM_UNITS-1 and groups take the indices above them, with every group numbered above all of its members. A request mask is the full mask of one resource, and the block resolves it to the resource of the mask's most significant set bit. Default topology: G0 (bit 4) holds units 0 and 1, G1 (bit 5) holds units 1, 2 and 3, G2 (bit 6) holds G0 and G1. The full masks are therefore 7'b0010011, 7'b0101110 and 7'b1111111.
- R2: A valid request with a nonzero cycle count that names a free plain unit is granted in the same cycle. grant_vld_o is 1 and grant_unit_o is that unit's one-hot bit. A busy unit gives grant_vld_o = 0 and grant_unit_o = 0.
- R3: A group request resolves level by level until it reaches a plain unit. The granted unit is always free and lies inside the requested group. When no unit under the group is free, nothing is granted.
- R4: In each group on the selection path, the candidate is the lowest set bit of the rotation mask, and the picked member is then dropped from the rotation. When the rotation becomes empty, it reloads with the member mask XOR the removed set, and the removed set is cleared.
- R5: A candidate that is not free is dropped from the rotation, using the same reload rule, until a free candidate is found.
- R6: When a member goes from free to fully used, it is dropped from the rotation of every group that still holds it. If its bit is above that group's current candidate, it is also added to the removed set.
- R7: A group is free exactly when at least one of its members is free. Fill-up and release of members therefore pass up through nested groups.
- R8: A unit granted with a count of N stays busy for exactly N cycles. freed_o carries that unit's bit for exactly one cycle, the first cycle in which the unit is free again.
- R9: A request with a count of 0 grants nothing and changes no state.
- R10: After reset, every unit is free, every rotation holds all of its members, every removed set is empty and freed_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 1 | An allocation request is present |
| req_mask_i | input | NUM_UNITS+NUM_GROUPS | Full mask of the requested unit or group |
| req_cycles_i | input | CYC_W | Number of busy cycles to hold the chosen unit |
| grant_vld_o | output | 1 | A unit was granted this cycle |
| grant_unit_o | output | NUM_UNITS+NUM_GROUPS | One-hot bit of the granted plain unit |
| freed_o | output | NUM_UNITS | Units that became free at the last clock edge |

## Verification
The bench drives the overlapping topology, in which unit 1 belongs to both G0 and G1, so that one fill-up event must reshape two rotations. A design that drops the member from only one group would then repeat a unit or skip a free one. Three-member rotations in G1 are driven until a member above the candidate fills. A design that ignores the removed set would bring that member back into the rotation on the next reload and pick a different unit than the model. Nested G2 requests with one half of the tree full check that occupancy passes upward, since a wrong design would grant a busy unit or refuse a request that could be served. Zero-count requests and units whose count runs out exactly on the next request also get attention, because an off-by-one timer would shift the freed pulse and the re-grant by a cycle.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  localparam int MAXR = 16;

  typedef logic [MAXR-1:0] rmask_t;

  typedef struct packed {
    rmask_t rot;
    rmask_t rmv;
  } rot_t;

  function automatic rmask_t low_bit(rmask_t m);
    return m & (~m + rmask_t'(1));
  endfunction

  // drop one member bit from a rotation, reloading when it empties
  function automatic rot_t rot_drop(rot_t s, rmask_t bitm, rmask_t full);
    rot_t n;
    n = s;
    if (bitm > low_bit(s.rot)) n.rmv = s.rmv | bitm;
    n.rot = s.rot & ~bitm;
    if (n.rot == '0) begin
      n.rot = full ^ n.rmv;
      n.rmv = '0;
      if (n.rot == '0) n.rot = full;
    end
    return n;
  endfunction

  function automatic int unsigned top_index(rmask_t m);
    int unsigned r;
    r = 0;
    for (int i = 0; i < MAXR; i++) if (m[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/alloc_unit_timer.sv
module alloc_unit_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] cycles_i,
  output logic          busy_o,
  output logic          last_o,
  output logic          freed_o
);
  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      freed_o <= 1'b0;
    end else begin
      freed_o <= last_o;
      if (load_i)      cnt_q <= cycles_i;
      else if (busy_o) cnt_q <= cnt_q - CW'(1);
    end
  end

  assert_load_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_o);
  assert_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  assert_freed_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> freed_o);
endmodule

// File: rtl/alloc_group_rot.sv
module alloc_group_rot
  import alloc_pkg::*;
#(
  parameter rmask_t MEMBERS = rmask_t'(3)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  rmask_t ready_i,
  input  logic   on_path_i,
  input  rmask_t full_evt_i,
  output rmask_t pick_o
);
  rot_t cur_q, walk, nxt;

  // skip candidates that are not free (R5)
  always_comb begin
    walk = cur_q;
    for (int k = 0; k < 2*MAXR+1; k++) begin
      if ((low_bit(walk.rot) & ready_i) == '0)
        walk = rot_drop(walk, low_bit(walk.rot), MEMBERS);
    end
    pick_o = low_bit(walk.rot) & ready_i;
  end

  always_comb begin
    nxt = cur_q;
    if (on_path_i) nxt = rot_drop(walk, pick_o, MEMBERS);
    for (int m = 0; m < MAXR; m++) begin
      if (full_evt_i[m] && nxt.rot[m])
        nxt = rot_drop(nxt, rmask_t'(1) << m, MEMBERS);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= '{rot: MEMBERS, rmv: '0};
    else        cur_q <= nxt;
  end

  assert_pick_member_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(pick_o) && ((pick_o & ~MEMBERS) == '0)));
  assert_path_has_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    on_path_i |-> (pick_o != '0));
  assert_rot_within_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q.rot != '0) && ((cur_q.rot & ~MEMBERS) == '0));
  assert_removed_disjoint_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q.rmv & cur_q.rot) == '0);
endmodule

// File: rtl/grouped_unit_alloc.sv
module grouped_unit_alloc
  import alloc_pkg::*;
#(
  parameter int NUM_UNITS  = 4,
  parameter int NUM_GROUPS = 3,
  parameter int CYC_W      = 4,
  parameter logic [NUM_GROUPS-1:0][NUM_UNITS+NUM_GROUPS-1:0] GROUP_MEMBERS =
    {7'b0110000, 7'b0001110, 7'b0000011}
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_vld_i,
  input  logic [NUM_UNITS+NUM_GROUPS-1:0] req_mask_i,
  input  logic [CYC_W-1:0]                req_cycles_i,
  output logic                            grant_vld_o,
  output logic [NUM_UNITS+NUM_GROUPS-1:0] grant_unit_o,
  output logic [NUM_UNITS-1:0]            freed_o
);
  localparam int NR = NUM_UNITS + NUM_GROUPS;

  function automatic rmask_t ready_from(logic [NUM_UNITS-1:0] busy);
    rmask_t r;
    r = '0;
    for (int u = 0; u < NUM_UNITS; u++) r[u] = !busy[u];
    for (int g = 0; g < NUM_GROUPS; g++)
      r[NUM_UNITS+g] = |(rmask_t'(GROUP_MEMBERS[g]) & r);
    return r;
  endfunction

  logic [NUM_UNITS-1:0]  busy, last, load, busy_next;
  rmask_t                ready_now, ready_next, full_evt, req_sel;
  rmask_t                pick [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] on_path;
  int unsigned           req_id, chosen;
  logic                  req_ok;

  assign ready_now = ready_from(busy);
  assign req_id    = top_index(rmask_t'(req_mask_i));
  assign req_sel   = ready_now >> req_id;
  assign req_ok    = req_vld_i && (req_mask_i != '0) &&
                     (req_cycles_i != '0) && req_sel[0];

  // walk the hierarchy down to a plain unit
  always_comb begin
    int unsigned cur;
    on_path = '0;
    cur = req_id;
    for (int l = 0; l <= NUM_GROUPS; l++) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (req_ok && cur == NUM_UNITS + g && !on_path[g]) begin
          on_path[g] = 1'b1;
          cur = top_index(pick[g]);
        end
      end
    end
    chosen = cur;
  end

  always_comb begin
    for (int i = 0; i < NR; i++) grant_unit_o[i] = req_ok && (chosen == i);
    for (int u = 0; u < NUM_UNITS; u++) begin
      load[u]      = req_ok && (chosen == u);
      busy_next[u] = (busy[u] && !last[u]) || load[u];
    end
  end
  assign grant_vld_o = req_ok;
  assign ready_next  = ready_from(busy_next);
  assign full_evt    = ready_now & ~ready_next;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    alloc_unit_timer #(.CW(CYC_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load[u]),
      .cycles_i (req_cycles_i),
      .busy_o   (busy[u]),
      .last_o   (last[u]),
      .freed_o  (freed_o[u])
    );
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    alloc_group_rot #(.MEMBERS(rmask_t'(GROUP_MEMBERS[g]))) u_rot (
      .clk        (clk),
      .rst_n      (rst_n),
      .ready_i    (ready_now),
      .on_path_i  (on_path[g]),
      .full_evt_i (full_evt),
      .pick_o     (pick[g])
    );
  end

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o |-> ($onehot(grant_unit_o) && (grant_unit_o[NR-1:NUM_UNITS] == '0)));
  assert_grant_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o |-> ((grant_unit_o[NUM_UNITS-1:0] & busy) == '0));
  assert_grant_in_subtree_R1: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o |-> ((grant_unit_o & ~req_mask_i) == '0));
  assert_zero_cycles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld_i && req_cycles_i == '0) |-> !grant_vld_o);
endmodule

// File: tb/grouped_unit_alloc_tb.sv
`timescale 1ns/1ps
module grouped_unit_alloc_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       req_vld = 0;
  logic [6:0] req_mask = '0;
  logic [3:0] req_cycles = '0;
  logic       grant_vld;
  logic [6:0] grant_unit;
  logic [3:0] freed;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  grouped_unit_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld), .req_mask_i(req_mask),
    .req_cycles_i(req_cycles), .grant_vld_o(grant_vld),
    .grant_unit_o(grant_unit), .freed_o(freed)
  );

  // reference model (restated from the requirements)
  logic [6:0] mem [3] = '{7'b0000011, 7'b0001110, 7'b0110000};
  logic [6:0] fullm [7] = '{7'b0000001, 7'b0000010, 7'b0000100, 7'b0001000,
                            7'b0010011, 7'b0101110, 7'b1111111};
  int         mcnt [4];
  logic [6:0] mrot [3];
  logic [6:0] mrm  [3];
  logic [3:0] mfreed;

  function automatic logic [6:0] lsb7(logic [6:0] m);
    for (int i = 0; i < 7; i++) if (m[i]) return 7'(1) << i;
    return '0;
  endfunction

  function automatic logic [6:0] rdy_of(logic [3:0] busy);
    logic [6:0] r;
    r = {3'b000, ~busy};
    for (int g = 0; g < 3; g++) r[4+g] = (mem[g] & r) != 0;
    return r;
  endfunction

  task automatic drop(int g, logic [6:0] b);
    if (b > lsb7(mrot[g])) mrm[g] |= b;
    mrot[g] &= ~b;
    if (mrot[g] == 0) begin
      mrot[g] = mem[g] ^ mrm[g];
      mrm[g] = 0;
      if (mrot[g] == 0) mrot[g] = mem[g];
    end
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: res < 0 means idle
  task automatic apply(int res, int cyc, string tag);
    logic [3:0] busy, busy_n;
    logic [6:0] rdy, rdy_n, evt, exp_unit;
    bit exp_vld;
    int cur;
    @(negedge clk);
    req_vld    = (res >= 0);
    req_mask   = (res >= 0) ? fullm[res] : '0;
    req_cycles = 4'(cyc);
    #1;
    for (int u = 0; u < 4; u++) busy[u] = (mcnt[u] != 0);
    rdy = rdy_of(busy);
    exp_vld = (res >= 0) && (cyc != 0) && rdy[res];
    exp_unit = 0;
    cur = res;
    if (exp_vld) begin
      while (cur >= 4) begin
        int g;
        logic [6:0] c;
        g = cur - 4;
        while ((lsb7(mrot[g]) & rdy) == 0) drop(g, lsb7(mrot[g]));
        c = lsb7(mrot[g]);
        drop(g, c);
        for (int i = 0; i < 7; i++) if (c[i]) cur = i;
      end
      exp_unit = 7'(1) << cur;
    end
    check(grant_vld == exp_vld, tag, grant_vld, exp_vld);
    check(grant_unit == exp_unit, tag, grant_unit, exp_unit);
    check(freed == mfreed, "R8 freed", freed, mfreed);
    for (int u = 0; u < 4; u++) begin
      mfreed[u] = (mcnt[u] == 1);
      if (mcnt[u] > 0) mcnt[u]--;
      if (exp_vld && cur == u) mcnt[u] = cyc;
      busy_n[u] = (mcnt[u] != 0);
    end
    rdy_n = rdy_of(busy_n);
    evt = rdy & ~rdy_n;
    for (int g = 0; g < 3; g++)
      for (int m = 0; m < 7; m++)
        if (evt[m] && mrot[g][m]) drop(g, 7'(1) << m);
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int u = 0; u < 4; u++) mcnt[u] = 0;
    for (int g = 0; g < 3; g++) begin mrot[g] = mem[g]; mrm[g] = 0; end
    mfreed = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    apply(-1, 0, "R10 idle after reset");
    apply(0, 3, "R2 free unit granted");
    apply(0, 2, "R2 busy unit refused");
    apply(-1, 0, "R8 countdown");
    apply(-1, 0, "R8 countdown");
    apply(0, 1, "R8 regrant after free");
    apply(6, 0, "R9 zero count ignored");
    apply(6, 2, "R9 state unchanged after zero count");
    for (int i = 0; i < 4; i++) apply(5, 1, "R4 rotation in G1");
    apply(4, 2, "R1 resolves G0 mask");
    apply(3, 6, "R6 fill unit above candidate");
    for (int i = 0; i < 4; i++) apply(5, 1, "R6 removed set reload");
    apply(1, 5, "R5 make shared unit busy");
    apply(4, 1, "R5 skip busy candidate");
    apply(0, 4, "R7 fill G0");
    apply(4, 1, "R7 full group refused");
    apply(6, 3, "R3 nested pick");
    apply(6, 3, "R3 nested pick");
    apply(6, 3, "R3 all busy refused");
    for (int i = 0; i < 6; i++) apply(-1, 0, "R7 release propagates");
    apply(6, 2, "R7 group free again");

    for (int i = 0; i < 4000; i++) begin
      int res, cyc;
      res = int'($urandom_range(0, 6));
      cyc = int'($urandom_range(0, 6));
      if ($urandom_range(0, 7) == 0) res = -1;
      if (cyc == 0)      apply(res, cyc, "R9 random");
      else if (res >= 4) apply(res, cyc, "R3 random group");
      else               apply(res, cyc, "R2 random unit");
    end
    apply(-1, 0, "R8 drain");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule